// File: doc/BRIEF.md
# Alignment Marker Error Corruptor

This block sits on the transmit side of a multi-lane 64b/66b coding layer and damages chosen bits of outgoing blocks on purpose, so that a link partner's marker lock, lane deskew and error counters can be tested. Every lane carries one 66-bit block per valid beat. Each block has a 2-bit header and a 64-bit payload. The block tracks the marker slot on every lane with its own counter. Markers recur once per `AM_PERIOD` valid blocks, and the counter can be realigned to an upstream marker generator with a sync input.

While an external scheduler holds the corrupt strobe high for the block being presented, every enabled lane whose block is eligible has eight byte masks XORed into its payload and a 2-bit mask XORed into its header. Which blocks are eligible depends on a mode input. In markers-only mode, only marker blocks qualify. In all-blocks mode, every valid block qualifies. Byte k of the payload holds marker field k: the three marker bytes, the first parity byte, three more marker bytes, then the inverted parity byte. Byte 0 goes out first. Result, valid flag and marker flag all appear one clock after the input.

Top module: `am_err_corruptor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_marker`, `out_hdr` and `out_data` are all zero.
- R2: After reset, the first valid block and then every `AM_PERIOD`-th valid block are marker slots. Blocks presented with `in_valid` low neither advance the slot count nor count as markers.
- R3: A valid block presented with `am_sync` high is a marker slot. The next marker comes `AM_PERIOD` valid blocks after it.
- R4: For a corrupted block, bit j of `byte_mask[8k+7:8k]` inverts payload bit `8k+j`. Byte k=0 is the first marker byte, k=3 is the first parity byte and k=7 is the inverted parity byte.
- R5: For a corrupted block, bit b of `hdr_mask` inverts bit b of that lane's 2-bit header.
- R6: A lane whose `lane_en` bit is 0 passes its header and payload through unchanged.
- R7: When `all_blocks` is 0 (markers-only mode), non-marker blocks pass through unchanged on every lane.
- R8: When `all_blocks` is 1, every valid block on an enabled lane is corrupted while the strobe is high, marker or not.
- R9: When `corrupt` is 0, every lane passes through unchanged.
- R10: Output valid, header, payload and marker flag equal the input of exactly one cycle earlier, after any corruption. A block with `in_valid` low is copied unchanged.
- R11: All lanes flag a marker in the same output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented on all lanes |
| in_hdr | input | 2*LANES | Sync headers; lane l at [2l+1:2l] |
| in_data | input | 64*LANES | Payloads; lane l at [64l+63:64l] |
| am_sync | input | 1 | Current valid block is a marker; realigns the slot counters |
| corrupt | input | 1 | Corrupt strobe for the current block |
| all_blocks | input | 1 | 0 = markers only, 1 = every valid block |
| lane_en | input | LANES | Per-lane corruption enable |
| byte_mask | input | 64 | Eight byte masks; byte k at [8k+7:8k] |
| hdr_mask | input | 2 | Sync header flip mask |
| out_valid | output | 1 | Delayed valid |
| out_hdr | output | 2*LANES | Delayed, possibly corrupted headers |
| out_data | output | 64*LANES | Delayed, possibly corrupted payloads |
| out_marker | output | LANES | Delayed per-lane marker-slot flag |

## Verification
On every cycle, the assertions check several properties: the one-cycle transfer of valid, exact pass-through when the strobe is low or a lane is disabled, pass-through of non-marker blocks in markers-only mode, and agreement of the marker flags across lanes. The bench checks the rest. It confirms that the slot spacing and the `am_sync` realignment land markers on the right blocks. It also confirms that each mask bit lands on the right payload or header bit, and that all-blocks mode corrupts ordinary blocks. To do this it sweeps strobe, mode, enables and masks over many slots of a short marker period and compares against an arithmetic model.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int unsigned BLK_PAYLOAD_W = 64;
    localparam int unsigned BLK_HDR_W     = 2;
    localparam int unsigned FIELD_W       = 8;
    localparam int unsigned NUM_FIELDS    = BLK_PAYLOAD_W / FIELD_W;

    // field index inside the payload (byte 0 sent first)
    localparam int unsigned FLD_MK0  = 0;
    localparam int unsigned FLD_MK1  = 1;
    localparam int unsigned FLD_MK2  = 2;
    localparam int unsigned FLD_PAR  = 3;
    localparam int unsigned FLD_MK4  = 4;
    localparam int unsigned FLD_MK5  = 5;
    localparam int unsigned FLD_MK6  = 6;
    localparam int unsigned FLD_NPAR = 7;

    typedef enum logic {
        SCOPE_MARKERS = 1'b0,
        SCOPE_ALL     = 1'b1
    } corrupt_scope_e;

endpackage

// File: rtl/amc_slot_counter.sv
module amc_slot_counter #(
    parameter int unsigned PERIOD = 16384,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic realign,
    output logic is_slot
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        is_slot = realign || (cnt_q == '0);
        cnt_d   = cnt_q;
        if (adv) begin
            if (realign) begin
                cnt_d = CW'(1);
            end else if (cnt_q == CW'(PERIOD - 1)) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/amc_lane_xor.sv
module amc_lane_xor
    import amc_pkg::*;
(
    input  logic                     hit,
    input  logic [BLK_HDR_W-1:0]     hdr_in,
    input  logic [BLK_PAYLOAD_W-1:0] data_in,
    input  logic [BLK_PAYLOAD_W-1:0] byte_mask,
    input  logic [BLK_HDR_W-1:0]     hdr_mask,
    output logic [BLK_HDR_W-1:0]     hdr_out,
    output logic [BLK_PAYLOAD_W-1:0] data_out
);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] fmask;
        always_comb begin
            fmask = hit ? byte_mask[f*FIELD_W +: FIELD_W] : '0;
            data_out[f*FIELD_W +: FIELD_W] = data_in[f*FIELD_W +: FIELD_W] ^ fmask;
        end
    end

    always_comb begin
        hdr_out = hit ? (hdr_in ^ hdr_mask) : hdr_in;
    end

endmodule

// File: rtl/am_err_corruptor.sv
module am_err_corruptor
    import amc_pkg::*;
#(
    parameter int unsigned LANES     = 4,
    parameter int unsigned AM_PERIOD = 16384,
    localparam int unsigned DW       = LANES * BLK_PAYLOAD_W,
    localparam int unsigned HW       = LANES * BLK_HDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [HW-1:0]      in_hdr,
    input  logic [DW-1:0]      in_data,
    input  logic               am_sync,
    input  logic               corrupt,
    input  logic               all_blocks,
    input  logic [LANES-1:0]   lane_en,
    input  logic [63:0]        byte_mask,
    input  logic [1:0]         hdr_mask,
    output logic               out_valid,
    output logic [HW-1:0]      out_hdr,
    output logic [DW-1:0]      out_data,
    output logic [LANES-1:0]   out_marker
);

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] marker;
        logic [HW-1:0]    hdr;
        logic [DW-1:0]    data;
    } stage_t;

    stage_t         stage_d, stage_q;
    corrupt_scope_e scope;
    logic [LANES-1:0] slot_hit;
    logic [LANES-1:0] lane_hit;
    logic [HW-1:0]    hdr_mod;
    logic [DW-1:0]    data_mod;

    assign scope = corrupt_scope_e'(all_blocks);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        amc_slot_counter #(
            .PERIOD (AM_PERIOD)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (in_valid),
            .realign (am_sync),
            .is_slot (slot_hit[l])
        );

        always_comb begin
            lane_hit[l] = in_valid && corrupt && lane_en[l] &&
                          ((scope == SCOPE_ALL) || slot_hit[l]);
        end

        amc_lane_xor u_xor (
            .hit       (lane_hit[l]),
            .hdr_in    (in_hdr[l*BLK_HDR_W +: BLK_HDR_W]),
            .data_in   (in_data[l*BLK_PAYLOAD_W +: BLK_PAYLOAD_W]),
            .byte_mask (byte_mask),
            .hdr_mask  (hdr_mask),
            .hdr_out   (hdr_mod[l*BLK_HDR_W +: BLK_HDR_W]),
            .data_out  (data_mod[l*BLK_PAYLOAD_W +: BLK_PAYLOAD_W])
        );
    end

    always_comb begin
        stage_d        = stage_q;
        stage_d.valid  = in_valid;
        stage_d.marker = in_valid ? slot_hit : '0;
        stage_d.hdr    = hdr_mod;
        stage_d.data   = data_mod;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.valid;
    assign out_marker = stage_q.marker;
    assign out_hdr    = stage_q.hdr;
    assign out_data   = stage_q.data;

endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
    parameter int unsigned LANES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [LANES*2-1:0]    in_hdr,
    input logic [LANES*64-1:0]   in_data,
    input logic                  corrupt,
    input logic                  all_blocks,
    input logic [LANES-1:0]      lane_en,
    input logic                  out_valid,
    input logic [LANES*2-1:0]    out_hdr,
    input logic [LANES*64-1:0]   out_data,
    input logic [LANES-1:0]      out_marker
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_marker == '0)); // R10
    AST_NO_STROBE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !corrupt |=> (out_data == $past(in_data) && out_hdr == $past(in_hdr))); // R9
    AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_marker == '0) || (out_marker == {LANES{1'b1}})); // R11

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_LANE_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[l] |=> (out_data[l*64 +: 64] == $past(in_data[l*64 +: 64]) &&
                             out_hdr[l*2 +: 2] == $past(in_hdr[l*2 +: 2]))); // R6
        AST_PLAIN_BLOCK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_marker[l] && !$past(all_blocks)) |->
            (out_data[l*64 +: 64] == $past(in_data[l*64 +: 64]) &&
             out_hdr[l*2 +: 2] == $past(in_hdr[l*2 +: 2]))); // R7
    end

endmodule

bind am_err_corruptor amc_checker #(.LANES(LANES)) u_amc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_hdr     (in_hdr),
    .in_data    (in_data),
    .corrupt    (corrupt),
    .all_blocks (all_blocks),
    .lane_en    (lane_en),
    .out_valid  (out_valid),
    .out_hdr    (out_hdr),
    .out_data   (out_data),
    .out_marker (out_marker)
);

// File: tb/am_err_corruptor_bench.sv
module am_err_corruptor_bench;

    localparam int LANES = 2;
    localparam int PER   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [LANES*2-1:0] in_hdr = '0;
    logic [LANES*64-1:0] in_data = '0;
    logic               am_sync = 1'b0;
    logic               corrupt = 1'b0;
    logic               all_blocks = 1'b0;
    logic [LANES-1:0]   lane_en = '0;
    logic [63:0]        byte_mask = '0;
    logic [1:0]         hdr_mask = '0;
    logic               out_valid;
    logic [LANES*2-1:0] out_hdr;
    logic [LANES*64-1:0] out_data;
    logic [LANES-1:0]   out_marker;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int mcnt = 0;

    always #2 clk = ~clk;

    am_err_corruptor #(.LANES(LANES), .AM_PERIOD(PER)) u_am_err_corruptor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
        .in_data(in_data), .am_sync(am_sync), .corrupt(corrupt),
        .all_blocks(all_blocks), .lane_en(lane_en), .byte_mask(byte_mask),
        .hdr_mask(hdr_mask), .out_valid(out_valid), .out_hdr(out_hdr),
        .out_data(out_data), .out_marker(out_marker)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic block(input int i);
        logic is_m;
        logic [LANES*64-1:0] d;
        logic [LANES*2-1:0]  h;
        @(negedge clk);
        in_valid   = (i % 7) != 3;
        am_sync    = (i == 203) || (i == 341);
        corrupt    = i[0] ^ i[4];
        all_blocks = i[1];
        lane_en    = i[3:2];
        byte_mask  = {8{i[7:0]}} ^ (64'h0102040810204080 << (i % 11));
        hdr_mask   = i[6:5];
        for (int l = 0; l < LANES; l++) begin
            d[l*64 +: 64] = {32'(i) * 32'h9E3779B1, ~32'(i) ^ 32'(l * 32'h01010101)};
            h[l*2 +: 2]   = 2'(i + l);
        end
        in_data = d;
        in_hdr  = h;
        is_m = in_valid && (am_sync || mcnt == 0);
        if (in_valid) mcnt = am_sync ? 1 : ((mcnt == PER - 1) ? 0 : mcnt + 1);
        @(posedge clk);
        #1;
        chk("R10 valid", {63'd0, out_valid}, {63'd0, in_valid});
        chk(am_sync ? "R3 marker" : "R2 marker", {62'd0, out_marker}, {62'd0, {LANES{is_m}}});
        chk("R11 lanes agree", {63'd0, out_marker[0] == out_marker[1]}, 64'd1);
        for (int l = 0; l < LANES; l++) begin
            logic hit;
            string tag;
            hit = in_valid && corrupt && lane_en[l] && (all_blocks || is_m);
            if (!in_valid)                 tag = "R10 idle data";
            else if (!corrupt)             tag = "R9 strobe low";
            else if (!lane_en[l])          tag = "R6 lane off";
            else if (!all_blocks && !is_m) tag = "R7 plain block";
            else if (!is_m)                tag = "R8 all blocks";
            else                           tag = "R4 marker bytes";
            chk(tag, out_data[l*64 +: 64], d[l*64 +: 64] ^ (hit ? byte_mask : 64'd0));
            chk("R5 header", {62'd0, out_hdr[l*2 +: 2]}, {62'd0, h[l*2 +: 2] ^ (hit ? hdr_mask : 2'b00)});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R1 reset marker", {62'd0, out_marker}, 64'd0);
        chk("R1 reset data", out_data[63:0] | out_data[127:64], 64'd0);
        chk("R1 reset hdr", {60'd0, out_hdr}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after reset", {63'd0, out_valid}, 64'd0);
        for (int i = 0; i < 600; i++) block(i);
        // single-bit walk: each byte mask bit lands on its own payload bit
        for (int b = 0; b < 64; b++) begin
            @(negedge clk);
            in_valid = 1'b1; am_sync = 1'b1; corrupt = 1'b1; all_blocks = 1'b0;
            lane_en = 2'b01; byte_mask = 64'd1 << b; hdr_mask = 2'(b);
            in_data = '0; in_hdr = '0;
            mcnt = 1;
            @(posedge clk);
            #1;
            chk("R4 bit walk", out_data[63:0], 64'd1 << b);
            chk("R6 bit walk off", out_data[127:64], 64'd0);
            chk("R5 hdr walk", {62'd0, out_hdr[1:0]}, {62'd0, 2'(b)});
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule